// File: doc/BRIEF.md
# Random Word Register Interface

This block presents freshly generated 32-bit random words to software through a small register bus. A word source hands a new word to a single holding register. Software reads that register to consume the word. A status register reports whether a word is waiting, the live condition of the clock and seed-health monitors, and sticky copies of those two error conditions. One interrupt line combines data-ready with the sticky errors, gated by an enable input.

The real entropy path is out of scope. A word model stands in for it: a Galois LFSR paced by a refill counter. The model keeps one spare word ready while the holding register is occupied. A read can therefore be refilled in the same cycle. When no spare is waiting, the refill arrives a fixed number of cycles after the previous hand-off. Read data is decoded from the address every cycle. Only a read strobe aimed at the data offset consumes the word.

Top module: `rng_data_regif`

## Requirements
- R1: While reset is held, the data offset and status offset read 0, and the interrupt is low.
- R2: The data register sits at byte offset 0x8. While ready is 1 it reads as the held word. Bus writes to it change nothing.
- R3: A read strobe at 0x8 while ready is 1, with no spare word waiting, clears ready. While ready is 0, offset 0x8 reads as 0.
- R4: With the generator enabled, a word enters the holding register exactly REFILL_LAT clock edges after the previous word was taken. After reset release, the count starts with the first released edge as edge 1. The words are successive states of a 32-bit right-shift Galois LFSR with mask LFSR_TAPS, started from LFSR_SEED. The first word is one step past the seed.
- R5: While gen_en is 0 the refill count is frozen. The held word stays readable, and a spare word already made is still delivered.
- R6: The status register sits at 0x4, with these bits: bit 0 ready, bit 1 live clock error, bit 2 live seed error, bit 5 sticky clock error, bit 6 sticky seed error. All other bits are 0.
- R7: A sticky flag is set on the edge after its live input is seen high. A write to 0x4 with that flag's bit at 0 clears it. A write with the bit at 1 leaves it unchanged. When a set and a clear fall on the same edge, the set wins.
- R8: irq equals irq_en AND (ready OR sticky clock error OR sticky seed error), with no delay.
- R9: If a consuming read and a waiting spare word fall on the same edge, the spare word is latched and ready stays 1.
- R10: While ready is 1 and no consuming read occurs, the held word never changes, even when a spare word is waiting.
- R11: Offsets 0x0 and 0xC read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Word generator run enable |
| irq_en | input | 1 | Interrupt enable |
| clk_err | input | 1 | Live clock-monitor error |
| seed_err | input | 1 | Live seed-health error |
| bus_rd | input | 1 | Read strobe (consumes at data offset) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with REFILL_LAT set to 6, with the default seed and mask. A short refill interval brings many refills into a few thousand cycles, so spare words are often waiting when a read arrives. The same-cycle refill and the hold-off case both occur frequently under random reads. A cycle model in the bench steps the LFSR independently and predicts every word and every refill edge.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_DATA
    } reg_sel_e;

    localparam int ST_READY     = 0;
    localparam int ST_CLK_LIVE  = 1;
    localparam int ST_SEED_LIVE = 2;
    localparam int ST_CLK_STK   = 5;
    localparam int ST_SEED_STK  = 6;

endpackage

// File: rtl/rng_word_model.sv
module rng_word_model #(
    parameter int              W    = 32,
    parameter int              LAT  = 42,
    parameter logic [W-1:0]    SEED = W'(1),
    parameter logic [W-1:0]    TAPS = W'(32'hB4BC_D35C)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         take,
    output logic         vld,
    output logic [W-1:0] word
);

    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAT - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
        logic [W-1:0]  lfsr;
    } gen_st_t;

    gen_st_t s_d, s_q;

    function automatic logic [W-1:0] adv(input logic [W-1:0] v);
        logic [W-1:0] r;
        r = v >> 1;
        if (v[0]) r = r ^ TAPS;
        return r;
    endfunction

    always_comb begin
        s_d = s_q;
        if (s_q.pend && take) begin
            s_d.pend = 1'b0;
        end
        if (!s_q.pend && run) begin
            if (s_q.cnt == LAST) begin
                s_d.pend = 1'b1;
                s_d.cnt  = '0;
                s_d.lfsr = adv(s_q.lfsr);
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, pend: 1'b0, lfsr: SEED};
        end else begin
            s_q <= s_d;
        end
    end

    assign vld  = s_q.pend;
    assign word = s_q.lfsr;

endmodule

// File: rtl/rng_hold_reg.sv
module rng_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_vld,
    input  logic [W-1:0] src_word,
    input  logic         rd_hit,
    output logic         take,
    output logic         ready,
    output logic [W-1:0] data
);

    typedef struct packed {
        logic         rdy;
        logic [W-1:0] word;
    } hold_st_t;

    hold_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        take = src_vld && (!s_q.rdy || rd_hit);
        if (take) begin
            s_d.rdy  = 1'b1;
            s_d.word = src_word;
        end else if (rd_hit && s_q.rdy) begin
            s_d.rdy  = 1'b0;
            s_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = s_q.rdy;
    assign data  = s_q.word;

endmodule

// File: rtl/rng_err_flags.sv
module rng_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_err,
    input  logic seed_err,
    input  logic stat_wr,
    input  logic wd_clk,
    input  logic wd_seed,
    output logic stk_clk,
    output logic stk_seed
);

    typedef struct packed {
        logic clk_f;
        logic seed_f;
    } flag_st_t;

    flag_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.clk_f  = clk_err  | (s_q.clk_f  & ~(stat_wr & ~wd_clk));
        s_d.seed_f = seed_err | (s_q.seed_f & ~(stat_wr & ~wd_seed));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stk_clk  = s_q.clk_f;
    assign stk_seed = s_q.seed_f;

endmodule

// File: rtl/rng_data_regif.sv
module rng_data_regif
    import rng_regif_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 4,
    parameter int                REFILL_LAT = 42,
    parameter int                STAT_OFS   = 4,
    parameter int                DATA_OFS   = 8,
    parameter logic [DATA_W-1:0] LFSR_SEED  = DATA_W'(1),
    parameter logic [DATA_W-1:0] LFSR_TAPS  = DATA_W'(32'hB4BC_D35C)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              irq_en,
    input  logic              clk_err,
    input  logic              seed_err,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);

    reg_sel_e          sel;
    logic              rd_hit;
    logic              gen_vld;
    logic [DATA_W-1:0] gen_word;
    logic              gen_take;
    logic              dready;
    logic [DATA_W-1:0] data_q;
    logic              stk_clk;
    logic              stk_seed;
    logic [DATA_W-1:0] stat;

    always_comb begin
        case (bus_addr)
            A_STAT:  sel = SEL_STAT;
            A_DATA:  sel = SEL_DATA;
            default: sel = SEL_NONE;
        endcase
    end

    assign rd_hit = bus_rd && (sel == SEL_DATA);

    rng_word_model #(
        .W    (DATA_W),
        .LAT  (REFILL_LAT),
        .SEED (LFSR_SEED),
        .TAPS (LFSR_TAPS)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gen_en),
        .take  (gen_take),
        .vld   (gen_vld),
        .word  (gen_word)
    );

    rng_hold_reg #(
        .W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_vld  (gen_vld),
        .src_word (gen_word),
        .rd_hit   (rd_hit),
        .take     (gen_take),
        .ready    (dready),
        .data     (data_q)
    );

    rng_err_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_err  (clk_err),
        .seed_err (seed_err),
        .stat_wr  (bus_wr && (sel == SEL_STAT)),
        .wd_clk   (bus_wdata[ST_CLK_STK]),
        .wd_seed  (bus_wdata[ST_SEED_STK]),
        .stk_clk  (stk_clk),
        .stk_seed (stk_seed)
    );

    always_comb begin
        stat               = '0;
        stat[ST_READY]     = dready;
        stat[ST_CLK_LIVE]  = clk_err;
        stat[ST_SEED_LIVE] = seed_err;
        stat[ST_CLK_STK]   = stk_clk;
        stat[ST_SEED_STK]  = stk_seed;
    end

    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = stat;
            SEL_DATA: bus_rdata = dready ? data_q : '0;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = irq_en && (dready || stk_clk || stk_seed);

endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_en,
    input logic              irq,
    input logic              clk_err,
    input logic              seed_err,
    input logic              dready,
    input logic [DATA_W-1:0] data_q,
    input logic              gen_vld,
    input logic [DATA_W-1:0] gen_word,
    input logic              stk_clk,
    input logic              stk_seed
);

    logic consume;
    assign consume = bus_rd && (bus_addr == ADDR_W'(DATA_OFS));

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        dready && consume && !gen_vld |=> !dready); // R3

    AST_ZERO_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dready && bus_addr == ADDR_W'(DATA_OFS)) |-> bus_rdata == '0); // R3

    AST_READ_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        dready && consume && gen_vld |=> dready && data_q == $past(gen_word)); // R9

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dready && !consume |=> dready && $stable(data_q)); // R10

    AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err |=> stk_clk); // R7

    AST_SEED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err |=> stk_seed); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R8

endmodule

bind rng_data_regif rng_regif_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DATA_OFS (DATA_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_en    (irq_en),
    .irq       (irq),
    .clk_err   (clk_err),
    .seed_err  (seed_err),
    .dready    (dready),
    .data_q    (data_q),
    .gen_vld   (gen_vld),
    .gen_word  (gen_word),
    .stk_clk   (stk_clk),
    .stk_seed  (stk_seed)
);

// File: tb/sim_rng_data_regif.sv
module sim_rng_data_regif;

    localparam int          LAT  = 6;
    localparam logic [31:0] SEED = 32'h0000_0001;
    localparam logic [31:0] TAPS = 32'hB4BC_D35C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0, irq_en = 1'b0, clk_err = 1'b0, seed_err = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    logic b_gen = 1'b0, b_ien = 1'b0, b_cerr = 1'b0, b_serr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          m_cnt;
    logic        m_pend, m_dr, m_sc, m_ss;
    logic [31:0] m_word, m_data;

    always #2.5 clk = ~clk;

    rng_data_regif #(
        .DATA_W (32), .ADDR_W (4), .REFILL_LAT (LAT),
        .STAT_OFS (4), .DATA_OFS (8), .LFSR_SEED (SEED), .LFSR_TAPS (TAPS)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .gen_en (gen_en), .irq_en (irq_en),
        .clk_err (clk_err), .seed_err (seed_err), .bus_rd (bus_rd),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq (irq)
    );

    function automatic logic [31:0] next_word(input logic [31:0] v);
        logic [31:0] r;
        r = v >> 1;
        if (v[0]) r = r ^ TAPS;
        return r;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [3:0] a);
        logic [31:0] s;
        s = 32'h0;
        s[0] = m_dr; s[1] = b_cerr; s[2] = b_serr; s[5] = m_sc; s[6] = m_ss;
        case (a)
            4'h4:    return s;
            4'h8:    return m_dr ? m_data : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [31:0] wd, input string tag);
        logic hit, tk, stw;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        gen_en = b_gen; irq_en = b_ien; clk_err = b_cerr; seed_err = b_serr;
        #1;
        chk(bus_rdata, exp_rdata(a), tag);
        chk({31'h0, irq}, {31'h0, b_ien & (m_dr | m_sc | m_ss)}, "R8");
        hit = rd && (a == 4'h8);
        stw = wr && (a == 4'h4);
        tk  = m_pend && (!m_dr || hit);
        m_sc = b_cerr | (m_sc & ~(stw & ~wd[5]));
        m_ss = b_serr | (m_ss & ~(stw & ~wd[6]));
        if (tk) begin
            m_dr = 1'b1; m_data = m_word;
        end else if (hit && m_dr) begin
            m_dr = 1'b0; m_data = 32'h0;
        end
        if (m_pend && tk) begin
            m_pend = 1'b0;
        end else if (!m_pend && b_gen) begin
            if (m_cnt == LAT - 2) begin
                m_pend = 1'b1; m_cnt = 0; m_word = next_word(m_word);
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = 0; m_pend = 1'b0; m_dr = 1'b0; m_sc = 1'b0; m_ss = 1'b0;
        m_word = SEED; m_data = 32'h0;

        // R1: reset state observed at both register offsets
        repeat (3) @(posedge clk);
        @(negedge clk);
        gen_en = 1'b1; irq_en = 1'b1; bus_addr = 4'h8;
        #1 chk(bus_rdata, 32'h0, "R1");
        chk({31'h0, irq}, 32'h0, "R1");
        bus_addr = 4'h4;
        #1 chk(bus_rdata, 32'h0, "R1");
        @(posedge clk);
        #1 rst_n = 1'b1;

        b_gen = 1'b1; b_ien = 1'b1;
        // R4: first word lands exactly LAT edges after release
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 4'h4, 32'h0, "R4");
        // R10: spare waits, held word unchanged
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 4'h8, 32'h0, "R10");
        // R9: read collides with spare
        step(1'b1, 1'b0, 4'h8, 32'h0, "R9");
        step(1'b0, 1'b0, 4'h8, 32'h0, "R9");
        // R3 then R4: consume, zeros, refill after LAT
        step(1'b1, 1'b0, 4'h8, 32'h0, "R3");
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 4'h8, 32'h0, "R3");
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 4'h4, 32'h0, "R4");

        // R5: generator paused
        b_gen = 1'b0;
        step(1'b0, 1'b0, 4'h8, 32'h0, "R5");
        step(1'b1, 1'b0, 4'h8, 32'h0, "R5");
        step(1'b1, 1'b0, 4'h8, 32'h0, "R5");
        for (int i = 0; i < 3 * LAT; i++) step(1'b0, 1'b0, 4'h4, 32'h0, "R5");
        b_gen = 1'b1;
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 4'h4, 32'h0, "R5");

        // R6 / R7: live and sticky errors
        b_cerr = 1'b1;
        step(1'b0, 1'b0, 4'h4, 32'h0, "R6");
        b_cerr = 1'b0;
        step(1'b0, 1'b0, 4'h4, 32'h0, "R7");
        step(1'b0, 1'b1, 4'h4, 32'hFFFF_FFFF, "R7");
        step(1'b0, 1'b0, 4'h4, 32'h0, "R7");
        step(1'b0, 1'b1, 4'h4, 32'h0, "R7");
        step(1'b0, 1'b0, 4'h4, 32'h0, "R7");
        b_serr = 1'b1;
        step(1'b0, 1'b1, 4'h4, 32'h0, "R7");
        b_serr = 1'b0;
        step(1'b0, 1'b0, 4'h4, 32'h0, "R7");
        b_ien = 1'b0;
        step(1'b0, 1'b0, 4'h4, 32'h0, "R8");
        b_ien = 1'b1;
        step(1'b0, 1'b1, 4'h4, 32'h0, "R6");

        // R2: write to data offset ignored
        step(1'b0, 1'b1, 4'h8, 32'hDEAD_BEEF, "R2");
        step(1'b0, 1'b0, 4'h8, 32'h0, "R2");
        // R11: unmapped offsets
        step(1'b1, 1'b0, 4'h0, 32'h0, "R11");
        step(1'b1, 1'b1, 4'hC, 32'h1234_5678, "R11");

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] a;
            string      t;
            logic       rd, wr;
            case ($urandom_range(0, 3))
                0: begin a = 4'h0; t = "R11"; end
                1: begin a = 4'h4; t = "R6"; end
                2: begin a = 4'h8; t = "R3"; end
                default: begin a = 4'hC; t = "R11"; end
            endcase
            rd = ($urandom_range(0, 2) == 0);
            wr = ($urandom_range(0, 7) == 0);
            b_gen  = ($urandom_range(0, 7) != 0);
            b_ien  = ($urandom_range(0, 1) == 0);
            b_cerr = ($urandom_range(0, 19) == 0);
            b_serr = ($urandom_range(0, 19) == 0);
            step(rd, wr, a, $urandom, t);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule